// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the digital settings for four 64-position potentiometers. Each channel has a live 6-bit wiper value and four retained 6-bit setting slots. The live value selects one of 64 tap lines, and exactly one of those lines is driven high for each channel. A parallel command port accepts one command per cycle. A command can read or write a wiper, read or write a slot, copy between a wiper and one of its own channel's slots, or step a wiper up or down by one position.

The slots model non-volatile storage. The block reset `rst` does not clear them. Only their own initial reset `store_init` clears them. On `rst`, each wiper reloads from slot 0 of its own channel. Every write into a slot starts a fixed busy window that models the time a storage cell takes to program. A command that arrives during this window is dropped, and the drop is recorded in a sticky error flag.

Top module: `potbank_top`

## Requirements
- R1: While `rst` is high, each channel's wiper takes the value held in slot 0 of that channel. `rst` leaves all slot contents unchanged.
- R2: While `store_init` is high, all sixteen slots are cleared to 0.
- R3: Opcode 1 writes `cmd_data` into the wiper of channel `cmd_chan`. Opcode 0 reads that wiper. The read data appears on `rd_data` with `rd_valid` high in the cycle after the read command is accepted. `rd_valid` is low in every other cycle.
- R4: Opcode 3 writes `cmd_data` into slot `cmd_slot` of channel `cmd_chan`. Opcode 2 reads that slot, with the same one-cycle-late timing as R3.
- R5: Opcode 4 copies a channel's wiper into one of its own slots. Opcode 5 copies one of a channel's own slots into its wiper. No other channel's wiper or slots change.
- R6: Opcode 6 adds one to the wiper. A wiper already at 63 stays at 63.
- R7: Opcode 7 subtracts one from the wiper. A wiper already at 0 stays at 0.
- R8: For channel c, bits [c*64 +: 64] of `tap_sel` are one-hot, and the set bit's index equals the wiper value.
- R9: An accepted opcode 3 or 4 holds `busy` high for exactly BUSY_CYC consecutive cycles, starting in the cycle after acceptance.
- R10: A command presented while `busy` is high has no effect. It sets `err`, and `err` stays high until `rst`.
- R11: A slot read returns the value last written into that slot, even if the wiper has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset; wipers reload from slot 0 |
| store_init | input | 1 | Synchronous initial clear of the retained slots |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_chan | input | 2 | Channel index |
| cmd_slot | input | 2 | Slot index |
| cmd_data | input | 6 | Write data |
| rd_data | output | 6 | Read result |
| rd_valid | output | 1 | Read result valid, one cycle after the command |
| busy | output | 1 | Slot programming in progress |
| err | output | 1 | Sticky flag: a command was dropped while busy |
| tap_sel | output | 256 | Four one-hot 64-bit tap selects, channel 0 in the low bits |

## Verification
The case that needs care is the end of the busy window meeting a waiting command. The bench writes a slot and then holds an increment on the port for the whole window. Every busy cycle must drop the increment and raise the error flag. The first free cycle must then accept the increment exactly once. The bench judges this by counting the busy cycles seen, checking that the wiper moved by exactly one step, and checking that `err` is still high.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
    localparam int CH_N   = 4;
    localparam int SLOT_N = 4;
    localparam int VAL_W  = 6;
    localparam int CH_W   = $clog2(CH_N);
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int TAPS   = 1 << VAL_W;

    typedef enum logic [2:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_SLOT  = 3'd2,
        OP_WR_SLOT  = 3'd3,
        OP_SAVE     = 3'd4,
        OP_RESTORE  = 3'd5,
        OP_STEP_UP  = 3'd6,
        OP_STEP_DN  = 3'd7
    } op_e;

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [CH_W-1:0]   chan;
        logic [SLOT_W-1:0] slot;
        logic [VAL_W-1:0]  data;
    } cmd_t;

    function automatic logic writes_slot(op_e op);
        return (op == OP_WR_SLOT) || (op == OP_SAVE);
    endfunction

    function automatic logic is_read(op_e op);
        return (op == OP_RD_WIPER) || (op == OP_RD_SLOT);
    endfunction
endpackage

// File: rtl/potbank_store.sv
module potbank_store
    import potbank_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   init,
    input  logic                                   we,
    input  logic [CH_W-1:0]                        wchan,
    input  logic [SLOT_W-1:0]                      wslot,
    input  logic [VAL_W-1:0]                       wdata,
    output logic [CH_N-1:0][SLOT_N-1:0][VAL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (init) begin
            q <= '0;
        end else if (we) begin
            q[wchan][wslot] <= wdata;
        end
    end

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (init)
        !we |=> $stable(q)); // R11
endmodule

// File: rtl/potbank_busy.sv
module potbank_busy #(
    parameter int BUSY_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(BUSY_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R9
endmodule

// File: rtl/potbank_wiper.sv
module potbank_wiper
    import potbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] reset_val,
    input  logic             ld_en,
    input  logic [VAL_W-1:0] ld_val,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [VAL_W-1:0] wiper,
    output logic [TAPS-1:0]  tap
);
    localparam logic [VAL_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= reset_val;
        end else if (ld_en) begin
            wiper <= ld_val;
        end else if (step_up && wiper != TOP) begin
            wiper <= wiper + 1'b1;
        end else if (step_dn && wiper != '0) begin
            wiper <= wiper - 1'b1;
        end
    end

    always_comb begin
        tap        = '0;
        tap[wiper] = 1'b1;
    end

    AST_TAP_ONE: assert property (@(posedge clk) disable iff (rst)
        $countones(tap) == 1); // R8
    AST_INC_SAT: assert property (@(posedge clk) disable iff (rst)
        (step_up && !ld_en && wiper == TOP) |=> wiper == TOP); // R6
    AST_DEC_SAT: assert property (@(posedge clk) disable iff (rst)
        (step_dn && !ld_en && wiper == '0) |=> wiper == '0); // R7
    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst)
        rst |=> wiper == $past(reset_val)); // R1
endmodule

// File: rtl/potbank_top.sv
module potbank_top
    import potbank_pkg::*;
#(
    parameter int BUSY_CYC = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   store_init,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [CH_W-1:0]        cmd_chan,
    input  logic [SLOT_W-1:0]      cmd_slot,
    input  logic [VAL_W-1:0]       cmd_data,
    output logic [VAL_W-1:0]       rd_data,
    output logic                   rd_valid,
    output logic                   busy,
    output logic                   err,
    output logic [CH_N*TAPS-1:0]   tap_sel
);
    cmd_t cmd;
    logic acc;
    logic [CH_N-1:0][SLOT_N-1:0][VAL_W-1:0] slot_q;
    logic [CH_N-1:0][VAL_W-1:0] wiper;
    logic [VAL_W-1:0] ld_val;
    logic slot_we;

    always_comb begin
        cmd.valid = cmd_valid;
        cmd.op    = op_e'(cmd_op);
        cmd.chan  = cmd_chan;
        cmd.slot  = cmd_slot;
        cmd.data  = cmd_data;
    end

    assign acc     = cmd.valid && !busy && !rst;
    assign slot_we = acc && writes_slot(cmd.op);
    assign ld_val  = (cmd.op == OP_WR_WIPER) ? cmd.data : slot_q[cmd.chan][cmd.slot];

    potbank_store u_store (
        .clk   (clk),
        .init  (store_init),
        .we    (slot_we),
        .wchan (cmd.chan),
        .wslot (cmd.slot),
        .wdata ((cmd.op == OP_WR_SLOT) ? cmd.data : wiper[cmd.chan]),
        .q     (slot_q)
    );

    potbank_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (slot_we),
        .busy  (busy)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic hit;
        assign hit = acc && (cmd.chan == CH_W'(c));
        potbank_wiper u_wiper (
            .clk       (clk),
            .rst       (rst),
            .reset_val (slot_q[c][0]),
            .ld_en     (hit && (cmd.op == OP_WR_WIPER || cmd.op == OP_RESTORE)),
            .ld_val    (ld_val),
            .step_up   (hit && cmd.op == OP_STEP_UP),
            .step_dn   (hit && cmd.op == OP_STEP_DN),
            .wiper     (wiper[c]),
            .tap       (tap_sel[c*TAPS +: TAPS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err      <= 1'b0;
        end else begin
            rd_valid <= acc && is_read(cmd.op);
            if (acc && is_read(cmd.op)) begin
                rd_data <= (cmd.op == OP_RD_WIPER) ? wiper[cmd.chan]
                                                   : slot_q[cmd.chan][cmd.slot];
            end
            if (cmd.valid && busy) begin
                err <= 1'b1;
            end
        end
    end

    AST_RD_LATE: assert property (@(posedge clk) disable iff (rst)
        (acc && is_read(cmd.op)) |=> rd_valid); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> err); // R10
endmodule

// File: tb/tb_potbank_top.sv
module tb_potbank_top;
    import potbank_pkg::*;
    localparam int BUSY_CYC = 5;

    logic clk = 1'b0;
    logic rst, store_init, cmd_valid;
    logic [2:0] cmd_op;
    logic [CH_W-1:0] cmd_chan;
    logic [SLOT_W-1:0] cmd_slot;
    logic [VAL_W-1:0] cmd_data, rd_data;
    logic rd_valid, busy, err;
    logic [CH_N*TAPS-1:0] tap_sel;

    int total = 0, bad = 0;
    logic [VAL_W-1:0] exp_w [CH_N];
    logic [VAL_W-1:0] exp_s [CH_N][SLOT_N];
    logic exp_err;

    always #2.5 clk = ~clk;

    potbank_top #(.BUSY_CYC(BUSY_CYC)) dut (.*);

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [VAL_W-1:0] sat_step(logic [VAL_W-1:0] v, logic up);
        if (up) return (v == '1) ? v : v + 1'b1;
        return (v == '0) ? v : v - 1'b1;
    endfunction

    task automatic chk_taps(string req);
        for (int c = 0; c < CH_N; c++) begin
            total++;
            if (tap_sel[c*TAPS +: TAPS] != (64'd1 << exp_w[c])) begin
                bad++;
                $display("FAIL %s: ch%0d taps actual=%h expected one-hot at %0d",
                         req, c, tap_sel[c*TAPS +: TAPS], exp_w[c]);
            end
        end
    endtask

    // issue one accepted command and update the model; check reads
    task automatic do_cmd(op_e op, int ch, int sl, int d, string req);
        logic [VAL_W-1:0] expr;
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_chan = CH_W'(ch);
        cmd_slot = SLOT_W'(sl); cmd_data = VAL_W'(d);
        expr = (op == OP_RD_WIPER) ? exp_w[ch] : exp_s[ch][sl];
        case (op)
            OP_WR_WIPER: exp_w[ch] = VAL_W'(d);
            OP_WR_SLOT:  exp_s[ch][sl] = VAL_W'(d);
            OP_SAVE:     exp_s[ch][sl] = exp_w[ch];
            OP_RESTORE:  exp_w[ch] = exp_s[ch][sl];
            OP_STEP_UP:  exp_w[ch] = sat_step(exp_w[ch], 1'b1);
            OP_STEP_DN:  exp_w[ch] = sat_step(exp_w[ch], 1'b0);
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == OP_RD_WIPER || op == OP_RD_SLOT) begin
            chk({req, " rd_valid"}, int'(rd_valid), 1);
            chk({req, " rd_data"}, int'(rd_data), int'(expr));
        end else begin
            chk({req, " rd_valid low"}, int'(rd_valid), 0);
        end
    endtask

    task automatic read_all(string req);
        for (int c = 0; c < CH_N; c++) begin
            do_cmd(OP_RD_WIPER, c, 0, 0, req);
            for (int s = 0; s < SLOT_N; s++) do_cmd(OP_RD_SLOT, c, s, 0, req);
        end
    endtask

    initial begin
        int bcnt;
        void'($urandom(32'd4242));
        rst = 1'b1; store_init = 1'b1; cmd_valid = 1'b0;
        cmd_op = '0; cmd_chan = '0; cmd_slot = '0; cmd_data = '0;
        for (int c = 0; c < CH_N; c++) begin
            exp_w[c] = '0;
            for (int s = 0; s < SLOT_N; s++) exp_s[c][s] = '0;
        end
        exp_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; store_init = 1'b0;
        @(negedge clk);

        // reset state
        chk("R2 rd_valid after init", int'(rd_valid), 0);
        chk("R9 busy after init", int'(busy), 0);
        chk("R10 err after init", int'(err), 0);
        chk_taps("R8 init taps");
        read_all("R2 cleared slots");

        // directed: wiper write/read, saturation
        do_cmd(OP_WR_WIPER, 1, 0, 62, "R3 write");
        do_cmd(OP_STEP_UP, 1, 0, 0, "R6 up");
        do_cmd(OP_STEP_UP, 1, 0, 0, "R6 up sat");
        do_cmd(OP_RD_WIPER, 1, 0, 0, "R6 read 63");
        do_cmd(OP_WR_WIPER, 2, 0, 1, "R3 write");
        do_cmd(OP_STEP_DN, 2, 0, 0, "R7 dn");
        do_cmd(OP_STEP_DN, 2, 0, 0, "R7 dn sat");
        do_cmd(OP_RD_WIPER, 2, 0, 0, "R7 read 0");
        chk_taps("R8 after steps");

        // save/restore and stored read after wiper change
        do_cmd(OP_SAVE, 1, 2, 0, "R5 save");
        do_cmd(OP_WR_WIPER, 1, 0, 7, "R11 change wiper");
        do_cmd(OP_RD_SLOT, 1, 2, 0, "R11 slot kept");
        do_cmd(OP_RESTORE, 1, 2, 0, "R5 restore");
        do_cmd(OP_RD_WIPER, 1, 0, 0, "R5 restored");
        read_all("R5 no cross-channel");

        // busy window meets a waiting command
        do_cmd(OP_WR_SLOT, 0, 3, 9, "R4 write");
        do_cmd(OP_WR_WIPER, 0, 0, 20, "R3 write");
        do_cmd(OP_WR_SLOT, 3, 1, 33, "R4 write");
        cmd_valid = 1'b1; cmd_op = OP_STEP_UP; cmd_chan = 2'd0;
        bcnt = 0;
        while (busy) begin
            bcnt++;
            chk_taps("R10 dropped while busy");
            @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_w[0] = sat_step(exp_w[0], 1'b1);
        exp_err = 1'b1;
        chk("R9 busy length", bcnt, BUSY_CYC);
        chk("R10 err set", int'(err), 1);
        chk_taps("R10 single step after busy");
        read_all("R4 slots");

        // random mix
        for (int i = 0; i < 300; i++) begin
            op_e op = op_e'($urandom_range(7, 0));
            do_cmd(op, $urandom_range(3, 0), $urandom_range(3, 0),
                   $urandom_range(63, 0), "R4 random");
            chk_taps("R8 random");
            chk("R10 err sticky", int'(err), int'(exp_err));
        end

        // block reset: wipers reload from slot 0, slots retained
        do_cmd(OP_WR_SLOT, 2, 0, 45, "R1 prep");
        while (busy) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < CH_N; c++) exp_w[c] = exp_s[c][0];
        exp_err = 1'b0;
        @(negedge clk);
        chk("R10 err cleared by rst", int'(err), 0);
        chk_taps("R1 reload");
        read_all("R1 after rst");

        // initial clear again
        store_init = 1'b1; rst = 1'b1;
        repeat (2) @(negedge clk);
        store_init = 1'b0; rst = 1'b0;
        for (int c = 0; c < CH_N; c++) begin
            exp_w[c] = '0;
            for (int s = 0; s < SLOT_N; s++) exp_s[c][s] = '0;
        end
        @(negedge clk);
        read_all("R2 clear");
        chk_taps("R2 taps");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule